// File: doc/BRIEF.md
# SD Card SPI Write Response and Busy Monitor

This passive monitor sits beside an SPI link to an SD card and observes the bytes the card returns after a block write. While idle it skips the 0xFF filler the card drives before answering. The first other byte is the card's data-response token. The monitor sorts that token into one of four classes: write accepted, rejected for a CRC fault, rejected for a write fault, or not a legal token. It reports the class with a one-cycle strobe.

When the token says the write was accepted and the transfer was started as a single-block write, the monitor waits while the card is busy. Each 0x00 byte means the card is still programming. The monitor records the byte index of the first zero byte and of the most recent one. The first non-zero byte ends the busy period and triggers a one-cycle span report. A free-running byte index supplies the positions. The block does not sample SPI bits, decode commands or check data CRC. The upstream logic supplies whole bytes with a valid strobe, and a flag that tells whether the current transfer is a single-block write.

Top module: `sd_wr_resp_monitor`

## Requirements
- R1: A synchronous active-high reset returns the monitor to idle. It clears resp_class to 0, busy_act to 0, both strobes, both span indices and the byte index, so the first byte after reset has index 0.
- R2: While idle, a valid byte equal to 0xFF is filler. It produces no resp_vld strobe and leaves resp_class unchanged.
- R3: While idle, any other valid byte is taken as the token, and resp_vld pulses for one cycle in the cycle after it. A token whose low five bits equal 0x05 gives resp_class 1 (accepted), whatever the top three bits hold.
- R4: A token whose low five bits equal 0x0B gives resp_class 2 (rejected, CRC fault).
- R5: A token whose low five bits equal 0x0D gives resp_class 3 (rejected, write fault).
- R6: Any other token gives resp_class 4 (invalid), and the monitor stays idle. This includes every token with bit 0 clear and a 0x00 byte received while idle. resp_class holds its value until the next token or reset.
- R7: The monitor enters the busy wait only for an accepted token that arrives with wr_single high. Any rejected or invalid token, or an accepted token with wr_single low, leaves it idle, and the next non-0xFF byte is classified as a new token.
- R8: In the busy wait, the first 0x00 byte raises busy_act and sets span_start and span_end to that byte's index.
- R9: Each further 0x00 byte in the busy wait moves span_end to its own index and leaves span_start unchanged.
- R10: The first non-zero byte in the busy wait returns the monitor to idle and clears busy_act. If at least one zero byte was seen, span_vld pulses for one cycle, with the final span held on span_start and span_end. That byte is not classified as a token.
- R11: The byte index is 16 bits wide, advances by one on every valid byte in any state, and wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | byte_in holds a received byte this cycle |
| byte_in | input | 8 | Byte received from the card |
| wr_single | input | 1 | Current transfer is a single-block write |
| resp_vld | output | 1 | One-cycle strobe: a token was classified |
| resp_class | output | 3 | Class of the last token (0 none, 1 accepted, 2 CRC reject, 3 write reject, 4 invalid) |
| busy_act | output | 1 | Card has signalled busy and has not yet released |
| span_vld | output | 1 | One-cycle strobe: busy period ended |
| span_start | output | IDX_W (16) | Index of the first busy byte |
| span_end | output | IDX_W (16) | Index of the latest busy byte |

## Verification
The bench sends tokens with random top bits, so a decoder that compared all eight bits would report accepted writes as invalid. It sends an accepted token with wr_single low followed by a 0x00 byte. A design that ignored the flag would start a busy span there, when the byte should be classed as an invalid token. An accepted write that releases at once must give no span strobe. A long busy run must keep its first index. Another run is placed so that it crosses the wrap of the byte index, which catches a counter that saturates or is the wrong width. A reset in the middle of a busy period must restart the index at zero and drop busy_act.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

   typedef enum logic [2:0] {
      RESP_NONE    = 3'd0,
      RESP_ACCEPT  = 3'd1,
      RESP_CRC_REJ = 3'd2,
      RESP_WR_REJ  = 3'd3,
      RESP_INVALID = 3'd4
   } resp_class_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } mon_state_e;

endpackage

// File: rtl/sdmon_byte_ctr.sv
module sdmon_byte_ctr #(
   parameter int IDX_W        = 16,
   parameter bit IDX_SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
   localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

   generate
      if (IDX_W < 2) begin : g_bad_width
         $error("sdmon_byte_ctr: IDX_W must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;

   generate
      if (IDX_SATURATE) begin : g_sat
         assign idx_nxt = (idx_q == IDX_MAX) ? idx_q : idx_q + IDX_ONE;
      end else begin : g_wrap
         assign idx_nxt = idx_q + IDX_ONE;

         // R11
         idx_step_chk: assert property (@(posedge clk) disable iff (rst)
            step |=> (idx_q == IDX_W'($past(idx_q) + IDX_ONE)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       idx_q <= '0;
      else if (step) idx_q <= idx_nxt;
   end

   assign idx = idx_q;

endmodule

// File: rtl/sdmon_tok_classify.sv
module sdmon_tok_classify
   import sdmon_pkg::*;
#(
   parameter int                TOK_W    = 8,
   parameter int                MASK_W   = 5,
   parameter logic [MASK_W-1:0] ACC_CODE = 5'h05,
   parameter logic [MASK_W-1:0] CRC_CODE = 5'h0B,
   parameter logic [MASK_W-1:0] WRE_CODE = 5'h0D
) (
   input  logic [TOK_W-1:0] tok,
   output resp_class_e      cls
);
   generate
      if (MASK_W > TOK_W || MASK_W < 2) begin : g_bad_mask
         $error("sdmon_tok_classify: MASK_W out of range");
      end
      if (ACC_CODE[0] != 1'b1 || CRC_CODE[0] != 1'b1 || WRE_CODE[0] != 1'b1) begin : g_bad_lsb
         $error("sdmon_tok_classify: every token code needs bit 0 set");
      end
      if (ACC_CODE == CRC_CODE || ACC_CODE == WRE_CODE || CRC_CODE == WRE_CODE) begin : g_bad_codes
         $error("sdmon_tok_classify: token codes must differ");
      end
   endgenerate

   logic [MASK_W-1:0] low;
   assign low = tok[MASK_W-1:0];

   always_comb begin
      if      (low == ACC_CODE) cls = RESP_ACCEPT;
      else if (low == CRC_CODE) cls = RESP_CRC_REJ;
      else if (low == WRE_CODE) cls = RESP_WR_REJ;
      else                      cls = RESP_INVALID;
   end

endmodule

// File: rtl/sdmon_busy_span.sv
module sdmon_busy_span #(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             zero_hit,
   input  logic             first_hit,
   input  logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] span_start,
   output logic [IDX_W-1:0] span_end
);
   logic [IDX_W-1:0] start_q;
   logic [IDX_W-1:0] end_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= '0;
         end_q   <= '0;
      end else if (zero_hit) begin
         end_q <= idx;
         if (first_hit) start_q <= idx;
      end
   end

   // R9
   start_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (zero_hit && !first_hit) |=> (start_q == $past(start_q)));

   assign span_start = start_q;
   assign span_end   = end_q;

endmodule

// File: rtl/sd_wr_resp_monitor.sv
module sd_wr_resp_monitor
   import sdmon_pkg::*;
#(
   parameter int                 IDX_W        = 16,
   parameter bit                 IDX_SATURATE = 1'b0,
   parameter logic [7:0]         FILL_BYTE    = 8'hFF,
   parameter int                 MASK_W       = 5,
   parameter logic [MASK_W-1:0]  ACC_CODE     = 5'h05,
   parameter logic [MASK_W-1:0]  CRC_CODE     = 5'h0B,
   parameter logic [MASK_W-1:0]  WRE_CODE     = 5'h0D
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             byte_vld,
   input  logic [7:0]       byte_in,
   input  logic             wr_single,
   output logic             resp_vld,
   output logic [2:0]       resp_class,
   output logic             busy_act,
   output logic             span_vld,
   output logic [IDX_W-1:0] span_start,
   output logic [IDX_W-1:0] span_end
);
   localparam int TOK_W = 8;

   generate
      if (FILL_BYTE == 8'h00) begin : g_bad_fill
         $error("sd_wr_resp_monitor: FILL_BYTE must not be the busy value");
      end
   endgenerate

   mon_state_e       state_q;
   resp_class_e      tok_cls;
   resp_class_e      cls_q;
   logic [IDX_W-1:0] idx;
   logic             rvld_q;
   logic             busy_q;
   logic             svld_q;
   logic             tok_hit;
   logic             go_busy;
   logic             zero_hit;
   logic             rel_hit;

   sdmon_byte_ctr #(
      .IDX_W        (IDX_W),
      .IDX_SATURATE (IDX_SATURATE)
   ) i_ctr (
      .clk  (clk),
      .rst  (rst),
      .step (byte_vld),
      .idx  (idx)
   );

   sdmon_tok_classify #(
      .TOK_W    (TOK_W),
      .MASK_W   (MASK_W),
      .ACC_CODE (ACC_CODE),
      .CRC_CODE (CRC_CODE),
      .WRE_CODE (WRE_CODE)
   ) i_cls (
      .tok (byte_in),
      .cls (tok_cls)
   );

   assign tok_hit  = byte_vld && (state_q == ST_IDLE) && (byte_in != FILL_BYTE);
   assign go_busy  = tok_hit && (tok_cls == RESP_ACCEPT) && wr_single;
   assign zero_hit = byte_vld && (state_q == ST_BUSY) && (byte_in == 8'h00);
   assign rel_hit  = byte_vld && (state_q == ST_BUSY) && (byte_in != 8'h00);

   sdmon_busy_span #(
      .IDX_W (IDX_W)
   ) i_span (
      .clk        (clk),
      .rst        (rst),
      .zero_hit   (zero_hit),
      .first_hit  (!busy_q),
      .idx        (idx),
      .span_start (span_start),
      .span_end   (span_end)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cls_q   <= RESP_NONE;
         rvld_q  <= 1'b0;
         busy_q  <= 1'b0;
         svld_q  <= 1'b0;
      end else begin
         rvld_q <= tok_hit;
         svld_q <= rel_hit && busy_q;
         if (tok_hit) cls_q <= tok_cls;
         if (go_busy) state_q <= ST_BUSY;
         else if (rel_hit) state_q <= ST_IDLE;
         if (zero_hit) busy_q <= 1'b1;
         else if (rel_hit) busy_q <= 1'b0;
      end
   end

   assign resp_vld   = rvld_q;
   assign resp_class = cls_q;
   assign busy_act   = busy_q;
   assign span_vld   = svld_q;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (!busy_act && !resp_vld && !span_vld && resp_class == 3'd0));

   // R7
   reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_vld && resp_class != 3'd1) |=> !busy_act);

   // R8
   first_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_act) |-> (span_start == span_end));

   // R10
   span_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      span_vld |-> ($past(busy_act) && !busy_act && !resp_vld));

   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
      resp_vld |-> !busy_act);

endmodule

// File: tb/test_sd_wr_resp_monitor.sv
module test_sd_wr_resp_monitor;

   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_in = 8'h00;
   logic        wr_single = 1'b0;
   logic        resp_vld;
   logic [2:0]  resp_class;
   logic        busy_act;
   logic        span_vld;
   logic [15:0] span_start;
   logic [15:0] span_end;

   int n_cmp = 0;
   int n_bad = 0;

   // reference state, built from the requirements
   bit          m_busy, m_seen, m_rv, m_sv;
   logic [2:0]  m_cls;
   logic [15:0] m_idx, m_start, m_end;

   always #5 clk = ~clk;

   sd_wr_resp_monitor i_sd_wr_resp_monitor (
      .clk        (clk),
      .rst        (rst),
      .byte_vld   (byte_vld),
      .byte_in    (byte_in),
      .wr_single  (wr_single),
      .resp_vld   (resp_vld),
      .resp_class (resp_class),
      .busy_act   (busy_act),
      .span_vld   (span_vld),
      .span_start (span_start),
      .span_end   (span_end)
   );

   function automatic logic [2:0] exp_class(input logic [7:0] b);
      case (b[4:0])
         5'h05:   return 3'd1;
         5'h0B:   return 3'd2;
         5'h0D:   return 3'd3;
         default: return 3'd4;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk(tag, "resp_vld",   32'(resp_vld),   32'(m_rv));
      chk(tag, "resp_class", 32'(resp_class), 32'(m_cls));
      chk(tag, "busy_act",   32'(busy_act),   32'(m_seen));
      chk(tag, "span_vld",   32'(span_vld),   32'(m_sv));
      chk(tag, "span_start", 32'(span_start), 32'(m_start));
      chk(tag, "span_end",   32'(span_end),   32'(m_end));
   endtask

   task automatic model_step(input logic [7:0] b, input bit wr);
      m_rv = 1'b0;
      m_sv = 1'b0;
      if (!m_busy) begin
         if (b != 8'hFF) begin
            m_rv  = 1'b1;
            m_cls = exp_class(b);
            if (m_cls == 3'd1 && wr) m_busy = 1'b1;
         end
      end else if (b == 8'h00) begin
         if (!m_seen) begin
            m_start = m_idx;
            m_seen  = 1'b1;
         end
         m_end = m_idx;
      end else begin
         m_sv   = m_seen;
         m_seen = 1'b0;
         m_busy = 1'b0;
      end
      m_idx = m_idx + 16'd1;
   endtask

   task automatic send(input logic [7:0] b, input bit wr, input string tag);
      @(negedge clk);
      byte_vld  = 1'b1;
      byte_in   = b;
      wr_single = wr;
      model_step(b, wr);
      @(posedge clk);
      #2;
      chk_all(tag);
      byte_vld = 1'b0;
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1'b1;
      byte_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_busy = 0; m_seen = 0; m_rv = 0; m_sv = 0;
      m_cls = 3'd0; m_idx = 16'd0; m_start = 16'd0; m_end = 16'd0;
      #1;
      chk_all(tag);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd7741));
      do_reset("R1");

      // filler while idle
      send(8'hFF, 1'b1, "R2");
      send(8'hFF, 1'b0, "R2");
      // accepted with top bits set, then a busy span of three bytes
      send(8'hE5, 1'b1, "R3");
      send(8'h00, 1'b1, "R8");
      send(8'h00, 1'b1, "R9");
      send(8'h00, 1'b1, "R9");
      send(8'hFF, 1'b1, "R10");
      // rejects leave the monitor idle
      send(8'h2B, 1'b1, "R4");
      send(8'h00, 1'b1, "R6");
      send(8'h0D, 1'b1, "R5");
      send(8'h04, 1'b1, "R6");
      send(8'h55, 1'b1, "R6");
      // accepted without single-block flag: next zero is a token
      send(8'h05, 1'b0, "R7");
      send(8'h00, 1'b1, "R7");
      // accepted write with immediate release: no span report
      send(8'h05, 1'b1, "R3");
      send(8'hFE, 1'b1, "R10");
      send(8'hFF, 1'b1, "R2");
      // reset in the middle of a busy period
      send(8'h05, 1'b1, "R7");
      send(8'h00, 1'b1, "R8");
      do_reset("R1");
      send(8'h05, 1'b1, "R11");
      send(8'h00, 1'b1, "R11");
      send(8'h01, 1'b1, "R10");

      // constrained random transfers
      for (int it = 0; it < 400; it++) begin
         int          nfill;
         int          nzero;
         logic [7:0]  tok;
         bit          wr;
         nfill = int'($urandom_range(0, 3));
         for (int k = 0; k < nfill; k++) send(8'hFF, 1'b1, "R2");
         case ($urandom_range(0, 4))
            0, 1:    tok = {3'($urandom), 5'h05};
            2:       tok = {3'($urandom), 5'h0B};
            3:       tok = {3'($urandom), 5'h0D};
            default: tok = 8'($urandom);
         endcase
         wr = ($urandom_range(0, 3) != 0);
         send(tok, wr, (tok == 8'hFF) ? "R2" : "R6");
         nzero = int'($urandom_range(0, 6));
         for (int k = 0; k < nzero; k++) send(8'h00, wr, "R9");
         send(8'h01 + 8'($urandom_range(0, 200)), wr, "R10");
      end

      // index wrap across a busy span
      do_reset("R1");
      while (m_idx != 16'hFFFE) send(8'hFF, 1'b1, "R11");
      send(8'h05, 1'b1, "R11");
      send(8'h00, 1'b1, "R11");
      send(8'h00, 1'b1, "R11");
      send(8'hFF, 1'b1, "R11");
      chk("R11", "wrapped start", 32'(span_start), 32'h0000FFFF);
      chk("R11", "wrapped end",   32'(span_end),   32'h00000000);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule